// File: doc/BRIEF.md
# Dual-Mode Column Readout Shift Chain

This block turns a snapshot of pixel hit bits into serial streams, one per pixel column. A single load pulse captures every pixel of every column at once into a chain of output flip-flops, and the chain then shifts one stage per clock. All columns shift side by side, so one event leaves the block in as many cycles as a single column has stages.

The chain length depends on a mode input that is sampled together with the load. In per-pixel mode every pixel is its own channel, so a column of NROWS pixels needs NROWS shift cycles (256 with the default size). In grouped mode, GROUP vertically adjacent pixels (eight by default) form one large cell. Their hits are ORed into the flip-flop of the group's top pixel, and the other flip-flops of the group are skipped. A column then needs only NROWS/GROUP cycles (32 with the default size).

Control is a two-state sequencer. In IDLE, a load moves it to SHIFT (transition ACCEPT), which starts the shift-cycle counter at the chain length minus one. SHIFT returns to IDLE when the counter reaches zero (transition DRAIN) and otherwise stays in SHIFT (transition STEP). A load that arrives in SHIFT is dropped (transition REJECT) and increments a wrapping error counter.

Top module: `readout_chain`

## Requirements
- R1: After reset, busy is 0, every ser_out bit is 0 and err_cnt is 0.
- R2: A load seen at a clock edge while idle captures hits at that edge, and busy is 1 from that edge on.
- R3: In per-pixel mode (mode_grp = 0 at load), busy stays 1 for exactly NROWS cycles and then falls.
- R4: In per-pixel mode, during the j-th busy cycle (j from 0), ser_out[c] equals hits[c*NROWS + j], so row 0 comes out first.
- R5: In grouped mode (mode_grp = 1 at load), during the j-th busy cycle ser_out[c] equals the OR of hits[c*NROWS + j*GROUP] through hits[c*NROWS + j*GROUP + GROUP-1].
- R6: In grouped mode, busy stays 1 for exactly NROWS/GROUP cycles.
- R7: Every column shifts in the same cycles as the others, and each column's stream depends only on that column's hits.
- R8: A load that arrives while busy is ignored: the stream in progress and its length do not change.
- R9: Each ignored load increments err_cnt by one, modulo 2^ERR_W. Accepted loads leave err_cnt unchanged.
- R10: While busy is 0, every ser_out bit is 0.
- R11: Changes to mode_grp and hits after an accepted load have no effect on the readout in progress.
- R12: A load in the first idle cycle after a readout is accepted, so back-to-back readouts leave no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_grp | input | 1 | 0 = per-pixel chain, 1 = grouped chain; sampled at an accepted load |
| load | input | 1 | Parallel capture request |
| hits | input | NCOLS*NROWS | Hit bits; column c, row r sits at bit c*NROWS + r |
| ser_out | output | NCOLS | Serial data, one bit per column |
| busy | output | 1 | High during the shift cycles of a readout |
| err_cnt | output | ERR_W | Wrapping count of loads ignored while busy |

## Verification
The bench builds the block with 4 columns, 32 rows, groups of 8 and a 4-bit error counter. This makes a per-pixel readout 32 cycles long and a grouped readout 4 cycles long, so many whole events, in both modes and with random hit patterns, fit in a short run. It also means that one long readout with more than 16 rejected loads pushes err_cnt through its wrap. With only four stages, a grouped readout also reaches its last group after three shifts, so a missing zero fill or a shift by the wrong stride shows up at once.

// File: rtl/readout_pkg.sv
package readout_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/readout_seq.sv
module readout_seq
    import readout_pkg::*;
#(
    parameter int NROWS = 256,
    parameter int GROUP = 8,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             mode_grp,
    output logic             busy,
    output logic             cap,
    output logic             shf,
    output logic             mode_eff,
    output logic [ERR_W-1:0] err_cnt
);
    localparam int NGRP = NROWS / GROUP;
    localparam int CW   = (NROWS > 1) ? $clog2(NROWS) : 1;

    seq_state_t       state, state_nxt;
    logic [CW-1:0]    cnt;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (load) state_nxt = ST_SHIFT;
            ST_SHIFT: if (cnt == '0) state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state == ST_SHIFT);
        cap      = (state == ST_IDLE) && load;
        shf      = (state == ST_SHIFT);
        mode_eff = cap ? mode_grp : mode_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            mode_q  <= 1'b0;
            err_cnt <= '0;
        end else begin
            if (cap) begin
                cnt    <= mode_grp ? CW'(NGRP - 1) : CW'(NROWS - 1);
                mode_q <= mode_grp;
            end else if (shf && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (load && state == ST_SHIFT)
                err_cnt <= err_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/readout_column.sv
module readout_column #(
    parameter int NROWS = 256,
    parameter int GROUP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             shf,
    input  logic             mode_eff,
    input  logic [NROWS-1:0] hits,
    output logic             dout
);
    localparam int NGRP = NROWS / GROUP;

    logic [NROWS-1:0] stage;
    logic [NROWS-1:0] trk_nxt;
    logic [NROWS-1:0] grp_nxt;
    logic [NROWS-1:0] grp_ld;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar r = 0; r < GROUP; r++) begin : g_row
            localparam int IDX = g * GROUP + r;
            if (IDX == NROWS - 1) begin : g_tend
                assign trk_nxt[IDX] = 1'b0;
            end else begin : g_tmid
                assign trk_nxt[IDX] = stage[IDX + 1];
            end
            if (r != 0) begin : g_skip
                assign grp_nxt[IDX] = 1'b0;
                assign grp_ld[IDX]  = 1'b0;
            end else begin : g_top
                assign grp_ld[IDX] = |hits[IDX +: GROUP];
                if (g == NGRP - 1) begin : g_gend
                    assign grp_nxt[IDX] = 1'b0;
                end else begin : g_gmid
                    assign grp_nxt[IDX] = stage[IDX + GROUP];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   stage <= '0;
        else if (cap) stage <= mode_eff ? grp_ld : hits;
        else if (shf) stage <= mode_eff ? grp_nxt : trk_nxt;
    end

    assign dout = stage[0];
endmodule

// File: rtl/readout_chain.sv
module readout_chain #(
    parameter int NCOLS = 4,
    parameter int NROWS = 256,
    parameter int GROUP = 8,
    parameter int ERR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_grp,
    input  logic                   load,
    input  logic [NCOLS*NROWS-1:0] hits,
    output logic [NCOLS-1:0]       ser_out,
    output logic                   busy,
    output logic [ERR_W-1:0]       err_cnt
);
    logic cap, shf, mode_eff;
    logic [NCOLS-1:0] col_dout;

    readout_seq #(.NROWS(NROWS), .GROUP(GROUP), .ERR_W(ERR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .mode_grp(mode_grp),
        .busy(busy), .cap(cap), .shf(shf), .mode_eff(mode_eff),
        .err_cnt(err_cnt)
    );

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        readout_column #(.NROWS(NROWS), .GROUP(GROUP)) u_col (
            .clk(clk), .rst_n(rst_n), .cap(cap), .shf(shf),
            .mode_eff(mode_eff), .hits(hits[c*NROWS +: NROWS]),
            .dout(col_dout[c])
        );
    end

    assign ser_out = busy ? col_dout : '0;
endmodule

// File: rtl/readout_chain_chk.sv
module readout_chain_chk #(
    parameter int NCOLS = 4,
    parameter int NROWS = 256,
    parameter int GROUP = 8,
    parameter int ERR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode_grp,
    input logic                   load,
    input logic [NCOLS*NROWS-1:0] hits,
    input logic [NCOLS-1:0]       ser_out,
    input logic                   busy,
    input logic [ERR_W-1:0]       err_cnt
);
    localparam int NGRP = NROWS / GROUP;

    int   run_len;
    logic chk_mode;
    logic live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= 0;
            chk_mode <= 1'b0;
            live     <= 1'b0;
        end else begin
            live <= 1'b1;
            if (load && !busy) begin
                chk_mode <= mode_grp;
                run_len  <= 0;
            end else if (busy) begin
                run_len <= run_len + 1;
            end
        end
    end

    // R3 / R6: busy run length matches the mode sampled at load
    assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $fell(busy)) |->
            (run_len == (chk_mode ? NGRP : NROWS)));

    // R2: busy only rises after a load
    assert_rise_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(busy)) |-> $past(load));

    // R9: a load while busy bumps the error count
    assert_err_bump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy) |=> (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

    // R9: no other change of the error count
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && busy) |=> $stable(err_cnt));

    // R10: outputs quiet while idle
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_out == '0));
endmodule

bind readout_chain readout_chain_chk #(
    .NCOLS(NCOLS), .NROWS(NROWS), .GROUP(GROUP), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_grp(mode_grp), .load(load),
    .hits(hits), .ser_out(ser_out), .busy(busy), .err_cnt(err_cnt)
);

// File: tb/sim_readout_chain.sv
module sim_readout_chain;
    localparam int NC = 4;
    localparam int NR = 32;
    localparam int G  = 8;
    localparam int EW = 4;
    localparam int NG = NR / G;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode_grp = 1'b0;
    logic               load = 1'b0;
    logic [NC*NR-1:0]   hits = '0;
    logic [NC-1:0]      ser_out;
    logic               busy;
    logic [EW-1:0]      err_cnt;

    int n_run = 0;
    int n_fail = 0;
    int exp_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    readout_chain #(.NCOLS(NC), .NROWS(NR), .GROUP(G), .ERR_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_grp(mode_grp), .load(load),
        .hits(hits), .ser_out(ser_out), .busy(busy), .err_cnt(err_cnt)
    );

    function automatic logic [NC-1:0] exp_word(input logic [NC*NR-1:0] p,
                                               input logic m, input int j);
        logic [NC-1:0] w;
        for (int c = 0; c < NC; c++) begin
            if (!m) w[c] = p[c*NR + j];
            else    w[c] = |p[c*NR + j*G +: G];
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one readout; bad loads injected in busy cycles 1..n_bad
    task automatic frame(input logic m, input logic [NC*NR-1:0] p,
                         input int n_bad, input bit flip, input bit immed);
        int len;
        len = m ? NG : NR;
        if (!immed) @(negedge clk);
        hits = p; mode_grp = m; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        hits = ~p;                               // R11: changes after load
        check("R2 busy after load", 32'(busy), 32'd1);
        for (int j = 0; j < len; j++) begin
            if (j > 0) @(negedge clk);
            check("R3/R6 busy during readout", 32'(busy), 32'd1);
            check(m ? "R5 grouped data" : "R4 per-pixel data",
                  32'(ser_out), 32'(exp_word(p, m, j)));
            load = 1'b0;
            if (flip) mode_grp = ~m;             // R11
            if (j >= 1 && j <= n_bad && j <= len - 2) begin
                load = 1'b1;                     // R8: ignored
                exp_err++;
            end
        end
        @(negedge clk);
        load = 1'b0;
        check("R3/R6 busy falls", 32'(busy), 32'd0);
        check("R10 quiet when idle", 32'(ser_out), 32'd0);
        check("R9 error count", 32'(err_cnt), 32'(exp_err % (1 << EW)));
    endtask

    function automatic logic [NC*NR-1:0] rnd_pat(input int density);
        logic [NC*NR-1:0] v;
        for (int i = 0; i < NC*NR; i++) v[i] = (($urandom % 100) < density);
        return v;
    endfunction

    initial begin
        logic [NC*NR-1:0] p;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 ser_out", 32'(ser_out), 32'd0);
        check("R1 err_cnt", 32'(err_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: walking one in column 2, per-pixel (R4, R7)
        p = '0; p[2*NR + 5] = 1'b1;
        frame(1'b0, p, 0, 1'b0, 1'b0);
        // directed: single hit in last row of each group, grouped (R5, R7)
        p = '0; p[0*NR + 7] = 1'b1; p[1*NR + 15] = 1'b1; p[3*NR + 31] = 1'b1;
        frame(1'b1, p, 0, 1'b0, 1'b0);
        // all ones grouped, back-to-back per-pixel (R12)
        frame(1'b1, '1, 0, 1'b0, 1'b0);
        frame(1'b0, '1, 0, 1'b0, 1'b1);
        // many rejected loads -> wrap of err_cnt (R8, R9)
        frame(1'b0, rnd_pat(40), 20, 1'b0, 1'b0);
        // mode flip mid-readout (R11)
        frame(1'b1, rnd_pat(10), 1, 1'b1, 1'b0);
        frame(1'b0, rnd_pat(50), 3, 1'b1, 1'b0);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            frame(1'($urandom % 2), rnd_pat(5 + int'($urandom % 60)),
                  int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
        end

        // R10: stays quiet for idle cycles
        repeat (5) begin
            @(negedge clk);
            check("R10 idle quiet", 32'(ser_out), 32'd0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule